// File: doc/BRIEF.md
# Dual-Reference Selection Controller

This controller picks the operating mode and the active timing reference for a synchronizer that can follow one of two references, a primary and a secondary. It keeps a state made of a reference (primary or secondary) and a mode: Normal (tracking that reference), Holdover (keeping the last learned frequency) or Freerun (running from the master clock). The downstream phase-locked loop reads this state. A one-cycle corrector-enable pulse tells the phase-error corrector to absorb the step, so that output phase stays continuous across switches.

Every control input is taken only on clock edges where the 8 kHz frame strobe is high. In automatic control the controller reacts to the two loss-of-signal flags. A reference that goes bad first puts the block into Holdover on that same reference. A switch to the other reference follows only after a built-in guard qualifier confirms that the loss has lasted a programmable number of frames. A recovery inside the guard window returns the block to Normal on the original reference. In manual control the state follows the mode-select and reference-select inputs directly.

Top module: `refsel_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, the state is primary Normal (`cur_ref`=0, `cur_mode`=00) and `corr_en` is 0.
- R2: The state changes only on a rising clock edge where `frame_stb` is 1. Input changes between strobes have no effect on `cur_ref` or `cur_mode`.
- R3: In manual control (`auto_ctl`=0), a strobe loads the mode from `mode_sel`: 00 gives Normal, 01 gives Holdover, and 10 or 11 gives Freerun. The same strobe loads the reference from `ref_sel`: 0 selects primary, 1 selects secondary.
- R4: In automatic control, a Normal state whose own reference reports loss while its guard is not yet qualified moves to Holdover on the same reference.
- R5: In automatic control, when the current reference's guard is qualified, the current reference is lost and the other reference is good, the next strobe moves the block to Normal on the other reference.
- R6: In automatic control, a Holdover state whose own reference no longer reports loss returns to Normal on the same reference, with no switch.
- R7: In automatic control, with both loss flags set, the block stays in or enters Holdover on the last-used reference and never switches.
- R8: The guard for a reference becomes qualified only after its loss flag has been 1 at `GUARD_FRAMES` consecutive strobes, and it is usable from the strobe after that. A single strobe with the flag at 0 clears it at once and restarts the count.
- R9: `corr_en` is high for exactly the one cycle after a strobe whose new state is not Freerun and either has a different reference from the old state, or enters Normal from Holdover or Freerun. Otherwise it stays 0.
- R10: In automatic control, a Freerun state leaves for primary Normal if the primary is good. Failing that, it goes to secondary Normal if the secondary is good, and otherwise to primary Holdover. Automatic control never enters Freerun.
- R11: `cur_mode` is encoded as 00 Normal, 01 Holdover, 10 Freerun and never takes 11. `cur_ref` is 0 for primary and 1 for secondary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle 8 kHz frame strobe that qualifies all control inputs |
| auto_ctl | input | 1 | 1 = automatic control from the loss flags, 0 = manual control |
| loss_pri | input | 1 | Loss-of-signal flag of the primary reference |
| loss_sec | input | 1 | Loss-of-signal flag of the secondary reference |
| mode_sel | input | 2 | Manual mode request (00 Normal, 01 Holdover, 1x Freerun) |
| ref_sel | input | 1 | Manual reference request (0 primary, 1 secondary) |
| cur_ref | output | 1 | Reference of the current state, also the selected reference |
| cur_mode | output | 2 | Mode of the current state |
| corr_en | output | 1 | One-cycle phase-error corrector enable pulse |

## Verification
A wrong state register shows up on `cur_ref`/`cur_mode` in the cycle right after the strobe that should have set it. A wrong pulse decision shows up on `corr_en` in that same cycle. A guard counter that is off by one strobe, or that fails to restart on a clean frame, shows no symptom until the following strobe: the switch to the other reference then arrives one frame early, one frame late or never. The stimulus therefore steps strobe by strobe through the guard window, through a glitch that interrupts it, and through the both-lost case.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_FREE   = 2'b10
  } mode_e;

  typedef enum logic {
    REF_PRI = 1'b0,
    REF_SEC = 1'b1
  } ref_e;

  typedef struct packed {
    ref_e  refn;
    mode_e mode;
  } sel_state_t;

  localparam int NUM_REFS = 2;
endpackage

// File: rtl/refsel_guard.sv
// Asymmetric qualifier: slow to assert, immediate to clear.
module refsel_guard #(
  parameter int GUARD_FRAMES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic loss,
  output logic qual
);
  localparam int CW = $clog2(GUARD_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(GUARD_FRAMES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (stb) begin
      if (!loss) begin
        cnt  <= '0;
        qual <= 1'b0;
      end else if (cnt == LAST) begin
        qual <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: a clean frame drops the qualifier at once
  assert_clear_on_good_R8: assert property (@(posedge clk) disable iff (rst)
    (stb && !loss) |=> !qual);
  // R8: the qualifier only rises on a strobe that saw loss
  assert_rise_on_loss_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(qual) |-> ($past(stb) && $past(loss)));
endmodule

// File: rtl/refsel_auto_next.sv
module refsel_auto_next
  import refsel_pkg::*;
(
  input  sel_state_t cur,
  input  logic       loss_p,
  input  logic       loss_s,
  input  logic       qual_p,
  input  logic       qual_s,
  output sel_state_t nxt
);
  logic own_loss, oth_loss, own_qual;
  ref_e oth_ref;

  always_comb begin
    own_loss = (cur.refn == REF_PRI) ? loss_p : loss_s;
    oth_loss = (cur.refn == REF_PRI) ? loss_s : loss_p;
    own_qual = (cur.refn == REF_PRI) ? qual_p : qual_s;
    oth_ref  = (cur.refn == REF_PRI) ? REF_SEC : REF_PRI;
    nxt      = cur;
    case (cur.mode)
      MODE_NORMAL: begin
        if (own_loss) begin
          if (own_qual && !oth_loss) nxt = '{refn: oth_ref, mode: MODE_NORMAL};
          else                       nxt = '{refn: cur.refn, mode: MODE_HOLD};
        end
      end
      MODE_HOLD: begin
        if (!own_loss)                  nxt = '{refn: cur.refn, mode: MODE_NORMAL};
        else if (own_qual && !oth_loss) nxt = '{refn: oth_ref, mode: MODE_NORMAL};
      end
      default: begin
        if (!loss_p)      nxt = '{refn: REF_PRI, mode: MODE_NORMAL};
        else if (!loss_s) nxt = '{refn: REF_SEC, mode: MODE_NORMAL};
        else              nxt = '{refn: REF_PRI, mode: MODE_HOLD};
      end
    endcase
  end

  // R10: automatic control never chooses Freerun
  always_comb begin
    assert_no_auto_free_R10: assert (nxt.mode != MODE_FREE);
  end
endmodule

// File: rtl/refsel_manual_next.sv
module refsel_manual_next
  import refsel_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       ref_sel,
  output sel_state_t nxt
);
  always_comb begin
    nxt.refn = ref_sel ? REF_SEC : REF_PRI;
    case (mode_sel)
      2'b00:   nxt.mode = MODE_NORMAL;
      2'b01:   nxt.mode = MODE_HOLD;
      default: nxt.mode = MODE_FREE;
    endcase
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int GUARD_FRAMES = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_stb,
  input  logic       auto_ctl,
  input  logic       loss_pri,
  input  logic       loss_sec,
  input  logic [1:0] mode_sel,
  input  logic       ref_sel,
  output logic       cur_ref,
  output logic [1:0] cur_mode,
  output logic       corr_en
);
  localparam sel_state_t RESET_STATE = '{refn: REF_PRI, mode: MODE_NORMAL};

  logic [NUM_REFS-1:0] loss_vec;
  logic [NUM_REFS-1:0] qual_vec;
  sel_state_t st, nxt_auto, nxt_man, nxt;
  logic pulse;

  assign loss_vec = {loss_sec, loss_pri};

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_guard
    refsel_guard #(.GUARD_FRAMES(GUARD_FRAMES)) guard_i (
      .clk  (clk),
      .rst  (rst),
      .stb  (frame_stb),
      .loss (loss_vec[g]),
      .qual (qual_vec[g])
    );
  end

  refsel_auto_next auto_i (
    .cur    (st),
    .loss_p (loss_pri),
    .loss_s (loss_sec),
    .qual_p (qual_vec[0]),
    .qual_s (qual_vec[1]),
    .nxt    (nxt_auto)
  );

  refsel_manual_next man_i (
    .mode_sel (mode_sel),
    .ref_sel  (ref_sel),
    .nxt      (nxt_man)
  );

  always_comb begin
    nxt   = auto_ctl ? nxt_auto : nxt_man;
    pulse = (nxt.mode != MODE_FREE) &&
            ((nxt.refn != st.refn) ||
             (nxt.mode == MODE_NORMAL && st.mode != MODE_NORMAL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RESET_STATE;
      corr_en <= 1'b0;
    end else begin
      corr_en <= frame_stb && pulse;
      if (frame_stb) st <= nxt;
    end
  end

  assign cur_ref  = st.refn;
  assign cur_mode = st.mode;

  // R2: no state movement without a strobe
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable({cur_ref, cur_mode}));
  // R3: manual Normal request is obeyed on the requested reference
  assert_manual_normal_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !auto_ctl && mode_sel == 2'b00) |=>
      (cur_mode == MODE_NORMAL && cur_ref == $past(ref_sel)));
  // R7: both references lost keeps the reference and enters Holdover
  assert_both_lost_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && auto_ctl && loss_pri && loss_sec && cur_mode != MODE_FREE) |=>
      (cur_mode == MODE_HOLD && cur_ref == $past(cur_ref)));
  // R9: corrector pulse lasts one cycle and never lands in Freerun
  assert_corr_single_R9: assert property (@(posedge clk) disable iff (rst)
    corr_en |=> !corr_en);
  assert_corr_not_free_R9: assert property (@(posedge clk) disable iff (rst)
    corr_en |-> cur_mode != MODE_FREE);
  // R11: unused mode code never appears
  assert_legal_mode_R11: assert property (@(posedge clk) disable iff (rst)
    cur_mode != 2'b11);
endmodule

// File: tb/refsel_ctrl_tb.sv
module refsel_ctrl_tb_top;
  localparam int GF = 3;

  logic clk = 1'b0;
  logic rst, frame_stb, auto_ctl, loss_pri, loss_sec, ref_sel;
  logic [1:0] mode_sel;
  logic cur_ref, corr_en;
  logic [1:0] cur_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  refsel_ctrl #(.GUARD_FRAMES(GF)) dut_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .auto_ctl(auto_ctl),
    .loss_pri(loss_pri), .loss_sec(loss_sec), .mode_sel(mode_sel),
    .ref_sel(ref_sel), .cur_ref(cur_ref), .cur_mode(cur_mode), .corr_en(corr_en)
  );

  // {auto, loss_pri, loss_sec, mode_sel[1:0], ref_sel, exp_ref, exp_mode[1:0], exp_corr}
  localparam logic [9:0] VEC [0:30] = '{
    10'b0_0_0_00_1_1_00_1, // 0  R3 manual sec Normal, R9 pulse
    10'b0_0_0_01_1_1_01_0, // 1  R3 sec Holdover
    10'b0_0_0_01_0_0_01_1, // 2  R3 R9 ref change in Holdover
    10'b0_0_0_10_0_0_10_0, // 3  R3 Freerun
    10'b0_0_0_11_1_1_10_0, // 4  R3 code 11 Freerun, R9 no pulse
    10'b0_0_0_00_0_0_00_1, // 5  R9 Freerun to Normal
    10'b1_0_0_00_0_0_00_0, // 6  auto, all good
    10'b1_1_0_00_0_0_01_0, // 7  R4 loss -> Holdover
    10'b1_0_0_00_0_0_00_1, // 8  R6 recovery
    10'b1_1_0_00_0_0_01_0, // 9  R8 guard 1
    10'b1_1_0_00_0_0_01_0, // 10 R8 guard 2
    10'b1_1_0_00_0_0_01_0, // 11 R8 guard 3 (qualifies now)
    10'b1_1_0_00_0_1_00_1, // 12 R5 switch to secondary
    10'b1_0_0_00_0_1_00_0, // 13 no revert
    10'b1_1_1_00_0_1_01_0, // 14 R7 both lost
    10'b1_1_1_00_0_1_01_0, // 15 R7
    10'b1_1_1_00_0_1_01_0, // 16 R7
    10'b1_1_1_00_0_1_01_0, // 17 R7 guard qualified, still no switch
    10'b1_0_1_00_0_0_00_1, // 18 R5 primary back, switch
    10'b1_0_0_00_0_0_00_0, // 19
    10'b1_1_0_00_0_0_01_0, // 20 R8
    10'b1_1_0_00_0_0_01_0, // 21 R8
    10'b1_0_0_00_0_0_00_1, // 22 R8 glitch clears count
    10'b1_1_0_00_0_0_01_0, // 23 R8 restart
    10'b1_1_0_00_0_0_01_0, // 24 R8
    10'b1_1_0_00_0_0_01_0, // 25 R8
    10'b1_1_0_00_0_1_00_1, // 26 R5 switch after fresh count
    10'b0_0_0_10_0_0_10_0, // 27 manual Freerun
    10'b1_1_0_00_0_1_00_1, // 28 R10 Freerun -> sec Normal
    10'b0_0_0_10_0_0_10_0, // 29 manual Freerun
    10'b1_1_1_00_0_0_01_0  // 30 R10 Freerun -> pri Holdover
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) frame_stb = 1'b1;
    @(negedge clk) frame_stb = 1'b0;
  endtask

  initial begin
    rst = 1'b1; frame_stb = 1'b0; auto_ctl = 1'b0; loss_pri = 1'b0;
    loss_sec = 1'b0; mode_sel = 2'b00; ref_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", {cur_ref, cur_mode, corr_en}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {cur_ref, cur_mode, corr_en}, 4'b0000);

    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      {auto_ctl, loss_pri, loss_sec, mode_sel, ref_sel} = VEC[i][9:4];
      strobe();
      chk($sformatf("R3-R10 vector %0d", i), {cur_ref, cur_mode, corr_en}, VEC[i][3:0]);
    end

    // R9: pulse only one cycle; then R2: no strobe, no change
    auto_ctl = 1'b0; mode_sel = 2'b00; ref_sel = 1'b1;
    strobe();
    chk("R9 pulse", {cur_ref, cur_mode, corr_en}, 4'b1001);
    @(negedge clk);
    chk("R9 pulse ends", {3'b000, corr_en}, 4'b0000);
    mode_sel = 2'b10; ref_sel = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 no strobe ignored", {cur_ref, cur_mode, corr_en}, 4'b1000);
    auto_ctl = 1'b1; loss_sec = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 auto no strobe ignored", {cur_ref, cur_mode, corr_en}, 4'b1000);
    // R4 for the secondary, R11 encoding
    loss_pri = 1'b0;
    strobe();
    chk("R4 secondary loss -> Holdover", {cur_ref, cur_mode, corr_en}, 4'b1010);

    // R1: reset in mid-run
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 mid-run reset", {cur_ref, cur_mode, corr_en}, 4'b0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule